// File: doc/BRIEF.md
# Four-Channel Time-Division Serial Link

This block carries four single-bit channels from a sending end to a receiving end over one serial data line and a shared clock. The sending end runs a free-running slot counter. The counter is decoded into four active-low source enables. In each clock cycle exactly one enable is low, and only the enabled source reaches the line. All other sources count as disconnected.

The receiving end runs its own slot counter, which is aligned with the sending counter by a shared synchronous reset. It decodes that counter to steer the serial bit into the holding register of the current slot. Each received output keeps its value until its slot comes round again, so the four parallel outputs are a delayed copy of the four inputs. Only the serial line and the clock pass from one end to the other.

Top module: `tdm_link`

## Requirements
- R1: While `rst` is high at a rising clock edge, all `rxOut` bits clear to 0 after that edge and both slot counters return to slot 0. In the first cycle after reset is released, the block is in slot 0 (`txEnN` = 4'b1110).
- R2: In every cycle outside reset, exactly one bit of `txEnN` is 0. Bit k being 0 means slot k is active.
- R3: The slot advances by one at each clock edge in the order 0, 1, 2, 3, and then wraps back to 0. Over any four consecutive cycles, each channel is selected exactly once.
- R4: `lineData` equals `txIn[k]` for the active slot k, sampled in the same cycle. The inputs of the other three channels have no effect on `lineData`.
- R5: At the clock edge that ends slot k, `rxOut[k]` loads the value of `lineData`. The other three `rxOut` bits keep their values.
- R6: A new value held on `txIn[k]` appears on `rxOut[k]` no later than the fifth clock edge after it is applied.
- R7: A reset applied in the middle of the stream realigns both ends, and reception restarts from slot 0 with `rxOut` cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ends |
| rst | input | 1 | Synchronous reset, active high, aligns both slot counters |
| txIn | input | 4 | Parallel channel inputs at the sending end |
| txEnN | output | 4 | Active-low source enables, one low per cycle |
| lineData | output | 1 | Serial data line between the two ends |
| rxOut | output | 4 | Held parallel channel outputs at the receiving end |

## Verification
If the sending slot counter is wrong, `txEnN` breaks its rotation or stops being one-hot-low in the same cycle, and `lineData` carries the wrong channel's bit straight away. If the receiving counter falls out of step with the sending one, a channel's bit lands in a neighbouring `rxOut` bit at the next clock edge. A scoreboard that tracks the expected held outputs then shows the mismatch within one cycle. If a hold or reset fault occurs, an output that should have kept its value changes, or an output fails to clear after the reset edge.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  parameter int unsigned NUM_CH = 4;
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned LAST_SLOT = NUM_CH - 1;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [NUM_CH-1:0] txEnN;   // active-low source enables
    logic [NUM_CH-1:0] rxLoad;  // receive register load strobes
    logic              clrRx;   // clear all receive registers
  } strobe_t;

endpackage

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output strobe_t strb
);

  logic [SEL_W-1:0] txSlot;
  logic [SEL_W-1:0] rxSlot;

  // Sending-end slot counter
  always_ff @(posedge clk) begin
    if (rst)
      txSlot <= '0;
    else if (txSlot == SEL_W'(LAST_SLOT))
      txSlot <= '0;
    else
      txSlot <= txSlot + 1'b1;
  end

  // Receiving-end slot counter, aligned by the shared reset
  always_ff @(posedge clk) begin
    if (rst)
      rxSlot <= '0;
    else if (rxSlot == SEL_W'(LAST_SLOT))
      rxSlot <= '0;
    else
      rxSlot <= rxSlot + 1'b1;
  end

  // Decoders: active-low enables for senders, active-high loads for receivers
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign strb.txEnN[i]  = (txSlot != SEL_W'(i));
    assign strb.rxLoad[i] = (rxSlot == SEL_W'(i));
  end

  assign strb.clrRx = rst;

endmodule

// File: rtl/tdm_dp.sv
module tdm_dp
  import tdm_pkg::*;
(
  input  logic              clk,
  input  strobe_t           strb,
  input  logic [NUM_CH-1:0] txIn,
  output logic              lineData,
  output logic [NUM_CH-1:0] rxOut
);

  logic [NUM_CH-1:0] drive;

  // Each source contributes only while its enable is low; the rest are disconnected
  for (genvar i = 0; i < NUM_CH; i++) begin : g_src
    assign drive[i] = ~strb.txEnN[i] & txIn[i];
  end

  assign lineData = |drive;

  // Receive holding registers, one per channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_rx
    logic held;
    always_ff @(posedge clk) begin
      if (strb.clrRx)
        held <= 1'b0;
      else if (strb.rxLoad[i])
        held <= lineData;
    end
    assign rxOut[i] = held;
  end

endmodule

// File: rtl/tdm_link.sv
module tdm_link
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] txIn,
  output logic [NUM_CH-1:0] txEnN,
  output logic              lineData,
  output logic [NUM_CH-1:0] rxOut
);

  strobe_t strb;

  tdm_ctrl i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  tdm_dp i_dp (
    .clk      (clk),
    .strb     (strb),
    .txIn     (txIn),
    .lineData (lineData),
    .rxOut    (rxOut)
  );

  assign txEnN = strb.txEnN;

endmodule

// File: rtl/tdm_link_chk.sv
module tdm_link_chk
  import tdm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] txIn,
  input logic [NUM_CH-1:0] txEnN,
  input logic              lineData,
  input logic [NUM_CH-1:0] rxOut
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rxOut == '0) && (txEnN == ~NUM_CH'(1)));

  // R2
  one_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~txEnN) == 1);

  // R3
  slot_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (~txEnN) == {$past(~txEnN[NUM_CH-2:0]), $past(~txEnN[NUM_CH-1])});

  // R5
  rx_load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rxOut == (($past(~txEnN) & {NUM_CH{$past(lineData)}}) |
                       ($past(txEnN) & $past(rxOut))));

  // R4
  line_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (txIn == '0) |-> !lineData);

endmodule

bind tdm_link tdm_link_chk i_chk (.*);

// File: tb/test_tdm_link.sv
`timescale 1ns/100ps
module test_tdm_link;
  import tdm_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] txIn = '0;
  logic [NUM_CH-1:0] txEnN;
  logic              lineData;
  logic [NUM_CH-1:0] rxOut;

  int nCmp = 0;
  int nBad = 0;
  int mdlSlot = 0;
  logic [NUM_CH-1:0] expRx = '0;
  logic [NUM_CH-1:0] expQ[$];

  always #2.5 clk = ~clk;

  tdm_link i_tdm_link (
    .clk      (clk),
    .rst      (rst),
    .txIn     (txIn),
    .txEnN    (txEnN),
    .lineData (lineData),
    .rxOut    (rxOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected held outputs after each receive edge (R5)
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0) begin
      logic [NUM_CH-1:0] e;
      e = expQ.pop_front();
      chk(rxOut === e, "R5 rx held outputs", 32'(rxOut), 32'(e));
    end
  end

  // Driver: one slot per call, starting in the low clock phase
  task automatic step(input logic [NUM_CH-1:0] v);
    logic [NUM_CH-1:0] expEn;
    #0.5 txIn = v;
    #0.5;
    expEn = ~(NUM_CH'(1) << mdlSlot);
    chk(txEnN === expEn, "R2 R3 enable slot", 32'(txEnN), 32'(expEn));
    chk(lineData === v[mdlSlot], "R4 line bit", 32'(lineData), 32'(v[mdlSlot]));
    expRx[mdlSlot] = v[mdlSlot];
    expQ.push_back(expRx);
    mdlSlot = (mdlSlot == NUM_CH - 1) ? 0 : mdlSlot + 1;
    @(negedge clk);
  endtask

  task automatic doReset(input string req);
    #1 rst = 1'b1;
    expQ.delete();
    @(negedge clk);
    @(negedge clk);
    chk(rxOut === '0, req, 32'(rxOut), 32'h0);
    chk(txEnN === ~NUM_CH'(1), req, 32'(txEnN), 32'(~NUM_CH'(1)));
    #0.5 rst = 1'b0;
    mdlSlot = 0;
    expRx = '0;
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    @(negedge clk);
    doReset("R1 reset state");

    // All ones, then all zeros
    for (int i = 0; i < 8; i++) step('1);
    for (int i = 0; i < 8; i++) step('0);

    // R4: toggle non-selected channels, the line must follow only the active one
    for (int i = 0; i < 8; i++) step(NUM_CH'(4'b1010));
    for (int i = 0; i < 8; i++) step(NUM_CH'(4'b0101));

    // Pseudo-random patterns
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[NUM_CH-1:0]);
    end

    // R6: latency from a new held input to its output
    for (int ch = 0; ch < NUM_CH; ch++) begin
      int n;
      logic [NUM_CH-1:0] v;
      v = rxOut ^ (NUM_CH'(1) << ch);
      n = 0;
      for (int k = 0; k < 6; k++) begin
        step(v);
        n++;
        if (rxOut[ch] === v[ch]) break;
      end
      chk(n <= 5, "R6 latency edges", 32'(n), 32'd5);
    end

    // R7: mid-stream reset at slot 2, then realigned stream
    step('1);
    step('1);
    doReset("R7 mid-stream reset");
    for (int i = 0; i < 12; i++) step(NUM_CH'(i));

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule